// File: doc/BRIEF.md
# Byte-Serial Effective Address Generator

This block forms operand and branch target addresses for an 8-bit processor whose address space is 16 bits wide. The instruction decoder pulses `op_start` in the opcode cycle. In that cycle it presents the addressing mode, the index register, the program counter of the opcode and the evaluated branch condition. The operand bytes that follow arrive one per cycle on a valid-qualified byte stream. The valid line may stay low for any number of cycles between two bytes.

Two modes are handled. In the indexed mode, two offset bytes are collected, high byte first, and the unsigned index is added to them. In the relative mode, one signed displacement byte is collected. It is added to the address just past the two-byte branch, or it is ignored when the branch is not taken. The result appears on `ea_out` together with a one-cycle `ea_done` strobe. It stays there until the next result.

Top module: `ea_gen`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `ea_out` reads 0x0000, `ea_done` reads 0 and no operation is pending.
- R2: With `op_mode`=0 (indexed), the first accepted operand byte is the high offset byte and the second is the low byte. The result is {high,low} plus the index, modulo 65536.
- R3: The index is unsigned and zero-extended: index 0xFF adds 255, and 0xFFFF with index 0xFF gives 0x00FE.
- R4: With `op_mode`=1 (relative) and the condition true, the result is pc+2 plus the sign-extended displacement, modulo 65536. 0x7F adds 127 and 0x80 subtracts 128.
- R5: With `op_mode`=1 and the condition false, the result is pc+2 modulo 65536, whatever the displacement byte.
- R6: `ea_done` is high for exactly one cycle, the cycle after the edge that accepts the last operand byte.
- R7: A byte is accepted only when `opnd_vld` is high, an operation is pending and `op_start` is low. Other bytes change neither the result nor the strobe.
- R8: Mode, index, program counter and condition are taken in the `op_start` cycle. Later changes on those inputs have no effect on the pending operation.
- R9: An `op_start` while bytes are still being collected abandons the partial operation and begins the new one. No strobe is produced for the abandoned one.
- R10: `ea_out` keeps its value from one `ea_done` pulse to the next.
- R11: An `op_start` in the same cycle as `ea_done` begins the next operation normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_start | input | 1 | Opcode cycle: begins an operation |
| op_mode | input | 1 | 0 = indexed 16-bit offset, 1 = relative branch |
| idx_val | input | 8 | Index register value |
| pc_val | input | 16 | Address of the opcode |
| br_cond | input | 1 | Branch condition, 1 = taken |
| opnd_vld | input | 1 | Operand byte valid |
| opnd_byte | input | 8 | Operand byte |
| ea_out | output | 16 | Effective address or next program counter |
| ea_done | output | 1 | One-cycle result strobe |

## Verification
Two events can share a cycle: the result strobe of one instruction and the `op_start` of the next. A second pair is `op_start` together with a valid byte. The bench issues operations back to back, so every new start falls in the strobe cycle of the previous one. Some starts also carry a junk valid byte. One cycle later the bench checks that the strobe has fallen and the old result is still held. The new result must then match the arithmetic model, which shows that the junk byte was not taken as an offset.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic {
    EA_IDX16 = 1'b0,
    EA_REL8  = 1'b1
  } ea_mode_e;

  typedef struct packed {
    ea_mode_e    mode;
    logic [7:0]  idx;
    logic [15:0] pc;
    logic        cond;
  } ea_ctx_t;

endpackage

// File: rtl/ea_opnd_collect.sv
module ea_opnd_collect
  import ea_pkg::*;
#(
  parameter int DW = 8,
  parameter int NB = 2,
  localparam int OW = DW * NB,
  localparam int CW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  ea_mode_e      mode,
  input  logic          vld,
  input  logic [DW-1:0] dat,
  output ea_mode_e      mode_q,
  output logic          active,
  output logic          last_acc,
  output logic [OW-1:0] ofs_next
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] need_cnt;
  logic [OW-1:0] ofs_q;
  logic          accept;

  assign need_cnt = (mode_q == EA_REL8) ? '0 : CW'(NB - 1);
  assign accept   = active & vld & ~start;
  assign last_acc = accept & (cnt == need_cnt);

  // byte lanes: the new byte enters lane 0, older bytes move one lane up
  for (genvar g = 0; g < NB; g++) begin : g_lane
    if (g == 0) begin : g_in
      assign ofs_next[DW-1:0] = dat;
    end else begin : g_sh
      assign ofs_next[g*DW +: DW] = ofs_q[(g-1)*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      ofs_q  <= '0;
      mode_q <= EA_IDX16;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      ofs_q  <= '0;
      mode_q <= mode;
    end else if (accept) begin
      ofs_q <= ofs_next;
      cnt   <= cnt + 1'b1;
      if (last_acc) begin
        active <= 1'b0;
        cnt    <= '0;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= need_cnt)); // R2

  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> ($stable(ofs_q) && !active)); // R7

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PC_STEP = 2
) (
  input  ea_mode_e      mode,
  input  logic [AW-1:0] ofs,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] pc,
  input  logic          cond,
  output logic [AW-1:0] ea
);

  function automatic logic [AW-1:0] f_idx_sum(input logic [AW-1:0] o,
                                               input logic [DW-1:0] x);
    return o + {{(AW-DW){1'b0}}, x};
  endfunction

  function automatic logic [AW-1:0] f_rel_next(input logic [AW-1:0] p,
                                                input logic [DW-1:0] d,
                                                input logic          c);
    logic [AW-1:0] base;
    base = p + AW'(PC_STEP);
    if (c) return base + {{(AW-DW){d[DW-1]}}, d};
    return base;
  endfunction

  always_comb begin
    if (mode == EA_REL8) ea = f_rel_next(pc, ofs[DW-1:0], cond);
    else                 ea = f_idx_sum(ofs, idx);
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PC_STEP = 2,
  localparam int NB = AW / DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_mode,
  input  logic [DW-1:0] idx_val,
  input  logic [AW-1:0] pc_val,
  input  logic          br_cond,
  input  logic          opnd_vld,
  input  logic [DW-1:0] opnd_byte,
  output logic [AW-1:0] ea_out,
  output logic          ea_done
);

  ea_mode_e      mode_in;
  ea_mode_e      mode_q;
  logic          active;
  logic          last_acc;
  logic [AW-1:0] ofs_next;
  logic [DW-1:0] idx_q;
  logic [AW-1:0] pc_q;
  logic          cond_q;
  logic [AW-1:0] ea_calc;

  assign mode_in = ea_mode_e'(op_mode);

  ea_opnd_collect #(.DW(DW), .NB(NB)) u_collect (
    .clk     (clk),
    .rst     (rst),
    .start   (op_start),
    .mode    (mode_in),
    .vld     (opnd_vld),
    .dat     (opnd_byte),
    .mode_q  (mode_q),
    .active  (active),
    .last_acc(last_acc),
    .ofs_next(ofs_next)
  );

  // instruction context, taken in the opcode cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      pc_q   <= '0;
      cond_q <= 1'b0;
    end else if (op_start) begin
      idx_q  <= idx_val;
      pc_q   <= pc_val;
      cond_q <= br_cond;
    end
  end

  ea_addr_calc #(.AW(AW), .DW(DW), .PC_STEP(PC_STEP)) u_calc (
    .mode(mode_q),
    .ofs (ofs_next),
    .idx (idx_q),
    .pc  (pc_q),
    .cond(cond_q),
    .ea  (ea_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_out  <= '0;
      ea_done <= 1'b0;
    end else begin
      ea_done <= last_acc;
      if (last_acc) ea_out <= ea_calc;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_acc |=> ea_done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ea_done |=> !ea_done); // R6

  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    !last_acc |=> !ea_done); // R7

  AST_EA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !last_acc |=> $stable(ea_out)); // R10

  AST_LAST_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
    last_acc |-> (active && !op_start)); // R9

endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_start;
  logic        op_mode;
  logic [7:0]  idx_val;
  logic [15:0] pc_val;
  logic        br_cond;
  logic        opnd_vld;
  logic [7:0]  opnd_byte;
  logic [15:0] ea_out;
  logic        ea_done;

  int total = 0;
  int bad = 0;
  logic [15:0] prev_exp = 16'h0000;
  logic        have_prev = 1'b0;

  always #2 clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_mode(op_mode),
    .idx_val(idx_val), .pc_val(pc_val), .br_cond(br_cond),
    .opnd_vld(opnd_vld), .opnd_byte(opnd_byte),
    .ea_out(ea_out), .ea_done(ea_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_idx(input int hi, input int lo, input int x);
    return (hi * 256 + lo + x) % 65536;
  endfunction

  function automatic int model_rel(input int pc, input int d, input bit c);
    int disp;
    disp = (d >= 128) ? d - 256 : d;
    if (!c) disp = 0;
    return (pc + 2 + disp + 65536) % 65536;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit last);
    opnd_vld  = 1'b1;
    opnd_byte = b;
    @(negedge clk);
    opnd_vld  = 1'b0;
    opnd_byte = ~b;
    if (!last) chk(ea_done == 1'b0, "R6 no early strobe", ea_done, 0);
  endtask

  task automatic gap_cycle();
    opnd_vld  = 1'b0;
    opnd_byte = 8'h3C;
    @(negedge clk);
    chk(ea_done == 1'b0, "R7 gap ignored", ea_done, 0);
  endtask

  // called at a negedge; returns at the negedge where the strobe is visible
  task automatic run_op(input bit mode, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] x, input logic [15:0] pc, input bit c,
                        input bit gap, input bit junk, input string req);
    int expv;
    op_start  = 1'b1;
    op_mode   = mode;
    idx_val   = x;
    pc_val    = pc;
    br_cond   = c;
    opnd_vld  = junk;
    opnd_byte = 8'hA5;
    @(negedge clk);
    op_start = 1'b0;
    op_mode  = ~mode;
    idx_val  = ~x;
    pc_val   = ~pc;
    br_cond  = ~c;
    opnd_vld = 1'b0;
    if (have_prev) begin
      chk(ea_done == 1'b0, "R11 strobe falls after overlap", ea_done, 0);
      chk(ea_out == prev_exp, "R10 result held", ea_out, prev_exp);
    end
    if (mode == 1'b0) begin
      if (gap) gap_cycle();
      send_byte(b0, 1'b0);
      if (gap) gap_cycle();
      send_byte(b1, 1'b1);
      expv = model_idx(b0, b1, x);
    end else begin
      if (gap) gap_cycle();
      send_byte(b0, 1'b1);
      expv = model_rel(pc, b0, c);
    end
    chk(ea_done == 1'b1, {req, " strobe"}, ea_done, 1);
    chk(ea_out == expv[15:0], req, ea_out, expv);
    prev_exp  = expv[15:0];
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; op_start = 1'b0; op_mode = 1'b0; idx_val = '0; pc_val = '0;
    br_cond = 1'b0; opnd_vld = 1'b1; opnd_byte = 8'hFF;
    repeat (3) @(negedge clk);
    chk(ea_out == 16'h0000, "R1 reset result", ea_out, 0);
    chk(ea_done == 1'b0, "R1 reset strobe", ea_done, 0);
    rst = 1'b0;
    // bytes with no operation pending after reset
    repeat (3) @(negedge clk);
    chk(ea_done == 1'b0 && ea_out == 16'h0000, "R1 R7 idle after reset", ea_out, 0);
    opnd_vld = 1'b0;

    // corner cases of the index
    run_op(1'b0, 8'h12, 8'h34, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0, "R2 idx 00");
    run_op(1'b0, 8'h12, 8'h34, 8'hFF, 16'h0, 1'b0, 1'b0, 1'b1, "R3 idx FF");
    run_op(1'b0, 8'hFF, 8'hFF, 8'hFF, 16'h0, 1'b0, 1'b1, 1'b0, "R3 wrap");
    run_op(1'b0, 8'hFF, 8'h80, 8'h80, 16'h0, 1'b0, 1'b0, 1'b0, "R3 unsigned");

    // index sweep with varied offsets, gaps and junk starts
    for (int i = 0; i < 256; i++) begin
      run_op(1'b0, 8'(i * 7 + 3), 8'(255 - i), 8'(i), 16'(i * 91), 1'(i % 2),
             (i % 3) == 0, (i % 5) == 0, "R2 R8 idx sweep");
    end

    // branch corner cases
    run_op(1'b1, 8'h7F, 8'h00, 8'h00, 16'h1000, 1'b1, 1'b0, 1'b0, "R4 +127");
    run_op(1'b1, 8'h80, 8'h00, 8'h00, 16'h1000, 1'b1, 1'b0, 1'b0, "R4 -128");
    run_op(1'b1, 8'h80, 8'h00, 8'h00, 16'h0010, 1'b1, 1'b0, 1'b1, "R4 wrap down");
    run_op(1'b1, 8'h7F, 8'h00, 8'h00, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R4 wrap up");
    run_op(1'b1, 8'h7F, 8'h00, 8'h00, 16'h1000, 1'b0, 1'b0, 1'b0, "R5 not taken 7F");
    run_op(1'b1, 8'h80, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b1, 1'b0, "R5 not taken wrap");

    // displacement sweep, both conditions, several bases
    for (int d = 0; d < 256; d++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] base;
        case (d % 4)
          0: base = 16'h1000;
          1: base = 16'hFFFE;
          2: base = 16'h0000;
          default: base = 16'h7FFF;
        endcase
        run_op(1'b1, 8'(d), 8'h00, 8'(d), base, 1'(c), (d % 7) == 0, (d % 3) == 0,
               c ? "R4 R8 rel sweep" : "R5 rel sweep");
      end
    end

    // abandon a half-collected indexed operation with a branch
    op_start = 1'b1; op_mode = 1'b0; idx_val = 8'h10; pc_val = 16'h0; br_cond = 1'b0;
    @(negedge clk);
    op_start = 1'b0;
    chk(ea_done == 1'b0, "R9 overlap strobe falls", ea_done, 0);
    opnd_vld = 1'b1; opnd_byte = 8'h12;
    @(negedge clk);
    op_start = 1'b1; op_mode = 1'b1; pc_val = 16'h2000; br_cond = 1'b1;
    opnd_vld = 1'b1; opnd_byte = 8'h99;
    @(negedge clk);
    op_start = 1'b0; opnd_vld = 1'b1; opnd_byte = 8'h04;
    chk(ea_done == 1'b0, "R9 no strobe for abandoned", ea_done, 0);
    chk(ea_out == prev_exp, "R9 result held", ea_out, prev_exp);
    @(negedge clk);
    opnd_vld = 1'b0;
    chk(ea_done == 1'b1, "R9 restart strobe", ea_done, 1);
    chk(ea_out == 16'h2006, "R9 restart result", ea_out, 16'h2006);
    prev_exp = 16'h2006;

    // stray bytes with nothing pending
    @(negedge clk);
    chk(ea_done == 1'b0, "R6 single cycle", ea_done, 0);
    for (int k = 0; k < 4; k++) begin
      opnd_vld = 1'b1; opnd_byte = 8'(k * 33 + 1);
      @(negedge clk);
      chk(ea_done == 1'b0 && ea_out == prev_exp, "R7 R10 stray byte", ea_out, prev_exp);
    end
    opnd_vld = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule